// File: doc/BRIEF.md
# Back-to-Back Frame Serializer

This block turns a ring of transmit descriptors into an unbroken serial bit stream. Each descriptor names a 76-byte payload in memory; the block fetches those bytes one at a time over a request/valid handshake, shifts them out most-significant bit first, and follows them at once with a 32-bit CRC. The result is a fixed 640-bit frame. Frames follow one another with no gap, so the line carries no idle bits while descriptors stay ready. Software has to queue filler frames when it has nothing to send.

The descriptor table itself lives outside the block. The block reads one entry through an index port, which returns the ready flag, the wrap flag and the base address. It retires entries through a close strobe that carries the index and an underrun flag; the owner of the table clears the ready flag on that strobe. Two commands steer the block. A stop pulse aborts the frame on the line and does not retire it. A restart pulse wakes the halted block and resumes at the current ring index. Two event pulses report a retired buffer and a transmit shortage.

Top module: `ctx_frame_tx`

## Requirements
- R1: After reset, tx_en, tx_bit, byte_req, cls_valid, evt_txb and evt_sht are all 0, and the block stays halted until a restart pulse arrives.
- R2: A frame is 640 bits. The first 608 bits are payload bytes 0..75, read from desc_addr+k, each sent MSB first. The last 32 bits are the CRC over those 608 bits. The CRC uses polynomial 0x04C11DB7, register preset to all ones, bits fed MSB first, and the result is complemented and sent from bit 31 down to bit 0.
- R3: While the next descriptor is ready, tx_en stays high across frame boundaries. The next frame's first bit directly follows the previous frame's last CRC bit.
- R4: When the last bit of a frame is on the line, cls_valid and evt_txb pulse for that cycle, with cls_idx set to the frame's descriptor and cls_ur = 0.
- R5: The descriptor after index i is 0 when i has its wrap flag set or i = NDESC-1. Otherwise it is i+1. Ready descriptors outside this ring order are never sent.
- R6: The following descriptor's ready flag is sampled while the first CRC bit is on the line. If it is not ready, or if it is the descriptor being sent, the frame still completes. Then evt_sht pulses together with the close, and tx_en falls.
- R7: A restart while halted resumes at the current index. If that descriptor is not ready, evt_sht pulses and no bit is sent.
- R8: A restart while frames are being sent has no effect on the bit stream.
- R9: A stop during a frame drops tx_en in the next cycle and retires nothing. The ring index stays the same, so the next restart sends the same descriptor again from payload byte 0.
- R10: If a payload byte has not arrived when the shifter needs it, tx_en falls. One cycle later the descriptor is closed with cls_ur = 1 and evt_txb, and the next restart begins at the descriptor after it.
- R11: If the following frame's byte 0 has not arrived by the end of a frame, the current frame closes normally. In the next cycle the following descriptor closes with cls_ur = 1, and the block halts.
- R12: At most one byte request is outstanding. byte_req is a single-cycle pulse, and the next pulse comes only after byte_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stop | input | 1 | Abort-and-halt command pulse |
| cmd_restart | input | 1 | Resume command pulse, used only while halted |
| desc_rd_idx | output | 3 | Ring entry being looked up |
| desc_ready | input | 1 | Ready flag of the looked-up entry |
| desc_wrap | input | 1 | Wrap flag of the looked-up entry |
| desc_addr | input | 24 | Payload base address of the looked-up entry |
| byte_req | output | 1 | Payload byte request pulse |
| byte_addr | output | 24 | Address of the requested byte |
| byte_valid | input | 1 | Requested byte is on byte_data |
| byte_data | input | 8 | Payload byte |
| tx_en | output | 1 | A frame bit is on tx_bit this cycle |
| tx_bit | output | 1 | Serial line bit |
| cls_valid | output | 1 | Descriptor retire strobe |
| cls_idx | output | 3 | Index being retired |
| cls_ur | output | 1 | Retired because of an underrun |
| evt_txb | output | 1 | Buffer-transmitted event pulse |
| evt_sht | output | 1 | Shortage event pulse |

## Verification
Faults in the bit counter or the shift register show up in the first captured frame. The bench compares each 640-bit frame in full against a frame it builds from its own memory model and CRC function. A fault in the ring index shows up as a frame from the wrong descriptor or as a close with the wrong index. A fault in the ready sampling shows up as a gap in the stream, a missing shortage pulse, or an extra frame. A fault in the underrun or stop path shows up within one cycle as a tx_en that stays high, or as a close that is missing or carries the wrong flag.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
   typedef enum logic [2:0] {
      S_HALT = 3'd0,
      S_CHK  = 3'd1,
      S_LOAD = 3'd2,
      S_RUN  = 3'd3,
      S_URC  = 3'd4
   } ctx_state_e;

   localparam int CRC_W = 32;
endpackage

// File: rtl/ctx_crc_ser.sv
module ctx_crc_ser #(
   parameter int          W          = 32,
   parameter logic [31:0] POLY       = 32'h04C11DB7,
   parameter bit          INVERT_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         upd,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] crc_o
);
   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= '1;
      else if (init)   q <= '1;
      else if (upd)    q <= {q[W-2:0], 1'b0} ^ ((q[W-1] ^ din) ? POLY[W-1:0] : '0);
      else if (shift)  q <= {q[W-2:0], 1'b1};
   end

   generate
      if (INVERT_OUT) begin : g_inv
         assign crc_o = ~q;
      end else begin : g_plain
         assign crc_o = q;
      end
   endgenerate
endmodule

// File: rtl/ctx_byte_fetch.sv
module ctx_byte_fetch #(
   parameter int AW     = 24,
   parameter int NBYTES = 76,
   localparam int OW    = $clog2(NBYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          flush,
   input  logic          take,
   input  logic [AW-1:0] base,
   output logic          byte_req,
   output logic [AW-1:0] byte_addr,
   input  logic          byte_valid,
   input  logic [7:0]    byte_data,
   output logic          buf_full,
   output logic [7:0]    buf_byte,
   output logic          last_req
);
   logic [OW-1:0] off;
   logic          outst, stale;

   assign byte_req  = en && !buf_full && !outst;
   assign byte_addr = base + AW'(off);
   assign last_req  = byte_req && (off == OW'(NBYTES-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off <= '0; outst <= 1'b0; stale <= 1'b0; buf_full <= 1'b0; buf_byte <= '0;
      end else begin
         if (byte_req) begin
            outst <= 1'b1;
            off   <= last_req ? '0 : off + 1'b1;
         end
         if (byte_valid && outst) begin
            outst <= 1'b0;
            if (!stale) begin
               buf_full <= 1'b1;
               buf_byte <= byte_data;
            end
         end
         if (take) buf_full <= 1'b0;
         if (flush) begin
            off      <= '0;
            buf_full <= 1'b0;
            stale    <= outst && !byte_valid;
         end else if (byte_valid && outst) begin
            stale <= 1'b0;
         end
      end
   end

   // R12: a request is never followed by another one in the next cycle
   a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      byte_req |=> !byte_req);
endmodule

// File: rtl/ctx_frame_tx.sv
module ctx_frame_tx #(
   parameter int          NDESC     = 8,
   parameter int          AW        = 24,
   parameter int          PAY_BYTES = 76,
   parameter logic [31:0] CRC_POLY  = 32'h04C11DB7,
   localparam int IW         = (NDESC > 1) ? $clog2(NDESC) : 1,
   localparam int PAY_BITS   = PAY_BYTES * 8,
   localparam int FRAME_BITS = PAY_BITS + ctx_pkg::CRC_W,
   localparam int PW         = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_stop,
   input  logic          cmd_restart,
   output logic [IW-1:0] desc_rd_idx,
   input  logic          desc_ready,
   input  logic          desc_wrap,
   input  logic [AW-1:0] desc_addr,
   output logic          byte_req,
   output logic [AW-1:0] byte_addr,
   input  logic          byte_valid,
   input  logic [7:0]    byte_data,
   output logic          tx_en,
   output logic          tx_bit,
   output logic          cls_valid,
   output logic [IW-1:0] cls_idx,
   output logic          cls_ur,
   output logic          evt_txb,
   output logic          evt_sht
);
   import ctx_pkg::*;

   generate
      if (NDESC < 1 || NDESC > 8) begin : g_bad_ring
         $error("ctx_frame_tx: NDESC must be 1..8");
      end
      if (PAY_BYTES < 2) begin : g_bad_len
         $error("ctx_frame_tx: PAY_BYTES must be at least 2");
      end
   endgenerate

   ctx_state_e      st;
   logic [PW-1:0]   pos;
   logic [7:0]      sreg;
   logic [IW-1:0]   cur, cur_nx, fidx, nn;
   logic            nxt_ok, fok;
   logic [31:0]     crc_v;
   logic            buf_full, last_req, take, flush, fetch_en;
   logic [7:0]      buf_byte;

   function automatic logic [IW-1:0] nxt_of(input logic [IW-1:0] i, input logic w);
      if (w || i == IW'(NDESC-1)) return '0;
      return i + 1'b1;
   endfunction

   logic in_pay, byte_end, at_last, at_crc0, run_ok;
   assign in_pay   = pos < PW'(PAY_BITS);
   assign byte_end = (pos[2:0] == 3'd7) && (pos < PW'(PAY_BITS-1));
   assign at_last  = pos == PW'(FRAME_BITS-1);
   assign at_crc0  = pos == PW'(PAY_BITS);
   assign run_ok   = (st == S_RUN) && !cmd_stop;

   assign desc_rd_idx = fidx;
   assign tx_en       = st == S_RUN;
   assign tx_bit      = tx_en && (in_pay ? sreg[7] : crc_v[31]);
   assign cls_valid   = (run_ok && at_last) || (st == S_URC);
   assign cls_idx     = cur;
   assign cls_ur      = st == S_URC;
   assign evt_txb     = cls_valid;
   assign evt_sht     = (run_ok && at_last && !nxt_ok) ||
                        (st == S_CHK && !cmd_stop && !desc_ready);

   assign fetch_en = fok && (st == S_LOAD || st == S_RUN);
   assign flush    = (st == S_HALT) && cmd_restart;
   assign take     = ((st == S_LOAD) && !cmd_stop && buf_full) ||
                     (run_ok && buf_full && (byte_end || (at_last && nxt_ok)));

   ctx_byte_fetch #(.AW(AW), .NBYTES(PAY_BYTES)) u_fetch (
      .clk, .rst_n, .en(fetch_en), .flush, .take, .base(desc_addr),
      .byte_req, .byte_addr, .byte_valid, .byte_data,
      .buf_full, .buf_byte, .last_req
   );

   ctx_crc_ser #(.W(32), .POLY(CRC_POLY), .INVERT_OUT(1'b1)) u_crc (
      .clk, .rst_n,
      .init((st == S_LOAD && take) || (run_ok && at_last)),
      .upd(run_ok && in_pay),
      .shift(run_ok && !in_pay),
      .din(sreg[7]),
      .crc_o(crc_v)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= S_HALT; pos <= '0; sreg <= '0; cur <= '0; cur_nx <= '0;
         fidx <= '0; nn <= '0; nxt_ok <= 1'b0; fok <= 1'b0;
      end else begin
         case (st)
            S_HALT: if (cmd_restart) begin
               fidx <= cur;
               fok  <= 1'b0;
               st   <= S_CHK;
            end
            S_CHK: begin
               if (cmd_stop || !desc_ready) st <= S_HALT;
               else begin
                  cur_nx <= nxt_of(fidx, desc_wrap);
                  fok    <= 1'b1;
                  st     <= S_LOAD;
               end
            end
            S_LOAD: begin
               if (cmd_stop) begin
                  st <= S_HALT; fok <= 1'b0;
               end else if (buf_full) begin
                  sreg <= buf_byte; pos <= '0; st <= S_RUN;
               end
            end
            S_RUN: begin
               if (cmd_stop) begin
                  st <= S_HALT; fok <= 1'b0;
               end else begin
                  pos <= pos + 1'b1;
                  if (in_pay) sreg <= {sreg[6:0], 1'b0};
                  if (byte_end) begin
                     if (buf_full) sreg <= buf_byte;
                     else begin st <= S_URC; fok <= 1'b0; end
                  end
                  if (last_req) begin
                     fidx <= cur_nx; fok <= 1'b0;
                  end
                  if (at_crc0) begin
                     nxt_ok <= desc_ready && (fidx != cur);
                     fok    <= desc_ready && (fidx != cur);
                     nn     <= nxt_of(fidx, desc_wrap);
                  end
                  if (at_last) begin
                     pos <= '0;
                     if (nxt_ok) begin
                        cur <= fidx; cur_nx <= nn;
                        if (buf_full) sreg <= buf_byte;
                        else begin st <= S_URC; fok <= 1'b0; end
                     end else begin
                        cur <= cur_nx; st <= S_HALT; fok <= 1'b0;
                     end
                  end
               end
            end
            S_URC: begin
               cur <= cur_nx; st <= S_HALT; fok <= 1'b0;
            end
            default: st <= S_HALT;
         endcase
      end
   end

   // R9: a stop outside the retire cycle silences the line and retires nothing
   a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stop && st != S_URC) |=> (!tx_en && !cls_valid));
   // R2: the bit position never leaves the frame while the line is active
   a_r2_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> (pos < PW'(FRAME_BITS)));
   // R6: a shortage always ends the stream
   a_r6_sht_halts: assert property (@(posedge clk) disable iff (!rst_n)
      evt_sht |=> !tx_en);
   // R10: an underrun retire leaves the block halted and quiet
   a_r10_ur_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_valid && cls_ur) |=> (!tx_en && !cls_valid));
endmodule

// File: tb/sim_ctx_frame_tx.sv
`timescale 1ns/1ps
module sim_ctx_frame_tx;
   localparam int FB = 640;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_stop = 1'b0, cmd_restart = 1'b0;
   logic [2:0] desc_rd_idx;
   logic desc_ready, desc_wrap;
   logic [23:0] desc_addr;
   logic byte_req; logic [23:0] byte_addr;
   logic byte_valid = 1'b0; logic [7:0] byte_data = '0;
   logic tx_en, tx_bit, cls_valid, cls_ur, evt_txb, evt_sht;
   logic [2:0] cls_idx;

   always #2.5 clk = ~clk;

   logic        tbl_ready [8];
   logic        tbl_wrap  [8];
   logic [23:0] dad       [8];
   assign desc_ready = tbl_ready[desc_rd_idx];
   assign desc_wrap  = tbl_wrap[desc_rd_idx];
   assign desc_addr  = dad[desc_rd_idx];

   ctx_frame_tx u0 (.*);

   int checks = 0, fails = 0;
   int exp_seq [8]; int exp_n = 0;
   int fi = 0, cls_n = 0, sht_n = 0, txb_n = 0, rises = 0;
   int cls_i [16]; int cls_u [16];
   logic slow_en = 1'b0; logic [23:0] slow_addr = '0;

   function automatic logic [7:0] memb(input logic [23:0] a);
      logic [7:0] m;
      m = a[7:0] * 8'd29;
      m = (m + a[15:8]) ^ 8'hC3 ^ a[23:16];
      return m;
   endfunction

   function automatic logic [FB-1:0] exp_frame(input logic [23:0] a);
      logic [FB-1:0] f; logic [31:0] c; logic [7:0] b; logic fb;
      f = '0; c = '1;
      for (int k = 0; k < 76; k++) begin
         b = memb(a + 24'(k));
         for (int j = 0; j < 8; j++) begin
            f[k*8+j] = b[7-j];
            fb = c[31] ^ b[7-j];
            c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
         end
      end
      c = ~c;
      for (int j = 0; j < 32; j++) f[608+j] = c[31-j];
      return f;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // memory responder
   initial begin
      int rcnt; logic [23:0] raddr;
      rcnt = 0; raddr = '0;
      forever begin
         @(negedge clk);
         byte_valid = 1'b0;
         if (rcnt > 0) begin
            rcnt--;
            if (rcnt == 0) begin byte_valid = 1'b1; byte_data = memb(raddr); end
         end
         if (byte_req) begin
            raddr = byte_addr;
            rcnt = (slow_en && byte_addr == slow_addr) ? 40 : 1 + int'($urandom % 5);
         end
      end
   end

   // line monitor and descriptor table owner
   initial begin
      logic [FB-1:0] cap; int cnt; logic prev;
      cnt = 0; prev = 1'b0; cap = '0;
      forever begin
         @(negedge clk); #1;
         if (tx_en) begin
            if (!prev) rises++;
            cap[cnt] = tx_bit; cnt++;
            if (cnt == FB) begin
               if (fi < exp_n)   // R2 frame content and CRC
                  chk(cap == exp_frame(dad[exp_seq[fi]]), "R2 frame bits", fi, exp_seq[fi]);
               else chk(1'b0, "R5 unexpected frame", fi, exp_n);
               fi++; cnt = 0;
            end
         end else cnt = 0;
         prev = tx_en;
         if (cls_valid) begin
            if (cls_n < 16) begin cls_i[cls_n] = int'(cls_idx); cls_u[cls_n] = int'(cls_ur); end
            cls_n++;
            tbl_ready[cls_idx] = 1'b0;
         end
         if (evt_sht) sht_n++;
         if (evt_txb) txb_n++;
      end
   end

   initial begin
      #(5.0 * 150000);
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      report(); $finish;
   end

   task automatic clr();
      fi = 0; cls_n = 0; sht_n = 0; txb_n = 0; rises = 0;
   endtask
   task automatic restart();
      @(negedge clk) cmd_restart = 1'b1;
      @(negedge clk) cmd_restart = 1'b0;
   endtask
   task automatic cls_chk(input int n, input int idx, input int ur, input string req);
      chk(cls_i[n] == idx, req, cls_i[n], idx);
      chk(cls_u[n] == ur,  req, cls_u[n], ur);
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 8; i++) begin
         tbl_ready[i] = 1'b0; tbl_wrap[i] = 1'b0; dad[i] = 24'($urandom);
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk); #1;
      // R1 reset state
      chk(!tx_en && !tx_bit && !byte_req, "R1 line idle", int'(tx_en), 0);
      chk(!cls_valid && !evt_txb && !evt_sht, "R1 events idle", int'(cls_valid), 0);

      // R7: restart with nothing ready
      clr(); restart(); repeat (20) @(negedge clk); #1;
      chk(sht_n == 1, "R7 shortage on restart", sht_n, 1);
      chk(rises == 0, "R7 nothing sent", rises, 0);

      // R3/R4/R5: ring 0,1,2 with wrap on 2; entry 3 ready but outside the ring
      clr();
      tbl_ready[0] = 1; tbl_ready[1] = 1; tbl_ready[2] = 1; tbl_ready[3] = 1; tbl_wrap[2] = 1;
      exp_seq[0] = 0; exp_seq[1] = 1; exp_seq[2] = 2; exp_n = 3;
      restart(); repeat (3*FB + 150) @(negedge clk); #1;
      chk(fi == 3, "R3 frame count", fi, 3);
      chk(rises == 1, "R3 no gap between frames", rises, 1);
      chk(cls_n == 3 && txb_n == 3, "R4 close count", cls_n, 3);
      cls_chk(0, 0, 0, "R4 close0"); cls_chk(1, 1, 0, "R4 close1"); cls_chk(2, 2, 0, "R4 close2");
      chk(sht_n == 1, "R6 shortage after wrap", sht_n, 1);
      chk(tbl_ready[3] == 1'b1, "R5 entry 3 untouched", int'(tbl_ready[3]), 1);
      chk(!tx_en, "R6 line halted", int'(tx_en), 0);

      // R6: single entry wrapping onto itself
      clr(); tbl_ready[0] = 1; tbl_wrap[0] = 1;
      exp_seq[0] = 0; exp_n = 1;
      restart(); repeat (2*FB) @(negedge clk); #1;
      chk(fi == 1, "R6 self-wrap one frame", fi, 1);
      chk(sht_n == 1 && cls_n == 1, "R6 self-wrap shortage", sht_n, 1);
      tbl_wrap[0] = 0;

      // R9: stop mid frame, then R8: restart during sending
      clr(); tbl_ready[0] = 1; tbl_ready[1] = 1;
      exp_seq[0] = 0; exp_seq[1] = 1; exp_n = 2;
      restart();
      while (!tx_en) @(negedge clk);
      repeat (300) @(negedge clk);
      cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0; #1;
      chk(!tx_en, "R9 line stops next cycle", int'(tx_en), 0);
      repeat (60) @(negedge clk); #1;
      chk(cls_n == 0, "R9 no retire on stop", cls_n, 0);
      chk(tbl_ready[0] == 1'b1, "R9 entry stays ready", int'(tbl_ready[0]), 1);
      clr(); restart();
      repeat (FB + 200) @(negedge clk);
      restart();   // R8: ignored while sending
      repeat (FB + 200) @(negedge clk); #1;
      chk(fi == 2, "R9 resend from byte 0 and R8", fi, 2);
      chk(rises == 1, "R8 stream unbroken", rises, 1);
      cls_chk(0, 0, 0, "R9 close after resend"); cls_chk(1, 1, 0, "R8 close1");

      // R10: payload underrun in entry 0 (cur is 2, entry 2 wraps to 0)
      clr(); tbl_ready[2] = 1; tbl_ready[0] = 1; tbl_ready[1] = 1;
      slow_en = 1'b1; slow_addr = dad[0] + 24'd10;
      exp_seq[0] = 2; exp_n = 1;
      restart(); repeat (2*FB + 100) @(negedge clk); #1;
      chk(fi == 1, "R10 one full frame", fi, 1);
      chk(cls_n == 2 && txb_n == 2, "R10 retire count", cls_n, 2);
      cls_chk(0, 2, 0, "R10 normal close"); cls_chk(1, 0, 1, "R10 underrun close");
      chk(!tx_en && sht_n == 0, "R10 halted", int'(tx_en), 0);
      slow_en = 1'b0;
      clr(); exp_seq[0] = 1; exp_n = 1;
      restart(); repeat (FB + 150) @(negedge clk); #1;
      chk(fi == 1 && cls_n == 1, "R10 restart from following entry", fi, 1);
      cls_chk(0, 1, 0, "R10 following entry close");

      // R11: next frame's first byte late at the frame boundary
      clr(); tbl_ready[2] = 1; tbl_ready[0] = 1;
      slow_en = 1'b1; slow_addr = dad[0];
      exp_seq[0] = 2; exp_n = 1;
      restart(); repeat (FB + 200) @(negedge clk); #1;
      chk(fi == 1, "R11 current frame whole", fi, 1);
      chk(cls_n == 2, "R11 two retires", cls_n, 2);
      cls_chk(0, 2, 0, "R11 current close"); cls_chk(1, 0, 1, "R11 next underrun close");
      chk(!tx_en, "R11 halted", int'(tx_en), 0);
      slow_en = 1'b0;

      report(); $finish;
   end
endmodule